// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block holds a small set of recently used virtual-to-physical page translations for a 32-bit two-level paged system with 4 KB pages. A lookup presents a 20-bit virtual page number, the 12-bit page offset and the current address-space context number. Every resident entry is compared in parallel. One cycle later the block reports a hit or a miss. On a hit it also returns the 22-bit physical page number, the permission and status bits, and the 34-bit physical address.

A miss tells the surrounding logic to start a table walk. The walker then writes the leaf entry it found through the refill port. An entry is either a normal 4 KB page or a 4 MB superpage. An entry is tied to one context unless it is marked global. Software-visible invalidation arrives on a flush port. The flush either clears everything or clears only the non-global entries of one context.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is low, and the first lookup reports a miss.
- R2: A lookup accepted in cycle N produces `rsp_valid` in cycle N+1. With `rsp_valid` high, exactly one of `rsp_hit` and `rsp_miss` is high.
- R3: On a hit, `rsp_ppn` and `rsp_perm` equal the stored values, and `rsp_paddr` is `{rsp_ppn, offset}`. The offset passes through unchanged in bits 11:0. The permission bit positions are 0 read, 1 write, 2 execute, 3 user, 4 global, 5 accessed and 6 dirty.
- R4: A non-global entry hits only when the lookup context equals the context stored with it. With a different context the lookup misses.
- R5: An entry whose `fill_perm` bit 4 (global) was set hits for any lookup context.
- R6: A superpage entry (`fill_super`=1) compares only VPN bits 19:10. Its returned PPN is `{stored PPN[21:10], lookup VPN[9:0]}`.
- R7: A refill goes into the lowest-numbered invalid entry whenever one exists, and the round-robin pointer does not move.
- R8: When all entries are valid, a refill overwrites the entry chosen by the round-robin pointer. The pointer starts at 0 and then steps by one, wrapping.
- R9: `flush_all` invalidates every entry at the next edge. A refill in the same cycle is dropped.
- R10: `flush_ctx_valid` invalidates only the non-global entries whose context equals `flush_ctx`. Other entries keep hitting, and a refill in the same cycle is dropped.
- R11: A lookup sees the buffer contents from before any refill in the same cycle. The new entry becomes visible to lookups from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_off | input | 12 | Lookup page offset |
| lk_ctx | input | CTX_W | Lookup address-space context |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | 20 | Refill virtual page number |
| fill_ctx | input | CTX_W | Refill context |
| fill_ppn | input | 22 | Refill physical page number |
| fill_perm | input | 7 | Refill permission/status bits (R,W,X,U,G,A,D from bit 0) |
| fill_super | input | 1 | Refill is a 4 MB superpage |
| flush_all | input | 1 | Invalidate every entry |
| flush_ctx_valid | input | 1 | Invalidate non-global entries of one context |
| flush_ctx | input | CTX_W | Context selected for the context flush |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss; a walk should start |
| rsp_ppn | output | 22 | Effective physical page number |
| rsp_perm | output | 7 | Permission/status bits of the hit entry |
| rsp_paddr | output | 34 | Physical address |

## Verification
The bench uses the default parameters: eight entries and a 9-bit context. With eight entries the buffer fills after a handful of refills. That makes pointer eviction, pointer wrap-relevant stepping, and the preference for a hole left by a context flush all reachable in a short run. The 9-bit context gives enough distinct values to mix two private contexts, a global entry, and a superpage in one buffer.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 22;
  localparam int OFF_W  = 12;
  localparam int LVL_W  = 10;
  localparam int PERM_W = 7;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int BIT_G  = 4;

  // Compare a stored page number with a presented one; a superpage
  // only uses the upper index field.
  function automatic logic vpn_match(input logic [VPN_W-1:0] tag,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic             sup);
    logic hi_eq, lo_eq;
    hi_eq = (tag[VPN_W-1:LVL_W] == vpn[VPN_W-1:LVL_W]);
    lo_eq = (tag[LVL_W-1:0] == vpn[LVL_W-1:0]);
    return hi_eq && (sup || lo_eq);
  endfunction

  // Effective frame: a superpage lets the low VPN field through.
  function automatic logic [PPN_W-1:0] eff_ppn(input logic [PPN_W-1:0] ppn,
                                               input logic [VPN_W-1:0] vpn,
                                               input logic             sup);
    return sup ? {ppn[PPN_W-1:LVL_W], vpn[LVL_W-1:0]} : ppn;
  endfunction
endpackage

// File: rtl/xlat_tag_cmp.sv
module xlat_tag_cmp
  import xlat_pkg::*;
#(
  parameter int CTX_W = 9
) (
  input  logic             ent_vld,
  input  logic             ent_sup,
  input  logic             ent_glb,
  input  logic [VPN_W-1:0] ent_vpn,
  input  logic [CTX_W-1:0] ent_ctx,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [CTX_W-1:0] q_ctx,
  output logic             hit
);
  logic ctx_ok;
  logic page_ok;

  assign ctx_ok  = ent_glb || (ent_ctx == q_ctx);
  assign page_ok = vpn_match(ent_vpn, q_vpn, ent_sup);
  assign hit     = ent_vld && ctx_ok && page_ok;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic               wr_fire,
  output logic [IDX_W-1:0]   victim,
  output logic               any_free
);
  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] first_free;
  logic             ptr_step;

  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free = ~&vld_vec;
  assign victim   = any_free ? first_free : rr_ptr;
  assign ptr_step = wr_fire && !any_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (ptr_step) begin
      rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // R7
  free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !vld_vec[victim]);

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_step |=> $stable(rr_ptr));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int CTX_W   = 9,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [19:0]       lk_vpn,
  input  logic [11:0]       lk_off,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              fill_valid,
  input  logic [19:0]       fill_vpn,
  input  logic [CTX_W-1:0]  fill_ctx,
  input  logic [21:0]       fill_ppn,
  input  logic [6:0]        fill_perm,
  input  logic              fill_super,
  input  logic              flush_all,
  input  logic              flush_ctx_valid,
  input  logic [CTX_W-1:0]  flush_ctx,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [21:0]       rsp_ppn,
  output logic [6:0]        rsp_perm,
  output logic [33:0]       rsp_paddr
);
  // entry state
  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] e_sup;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [CTX_W-1:0]   e_ctx  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [PERM_W-1:0]  e_perm [ENTRIES];

  // named internal events
  logic [ENTRIES-1:0] hit_vec;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic               fill_fire;
  logic               any_flush;
  logic [IDX_W-1:0]   victim;
  logic               any_free;

  assign any_flush = flush_all || flush_ctx_valid;
  assign fill_fire = fill_valid && !any_flush;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_line
      xlat_tag_cmp #(.CTX_W(CTX_W)) u_cmp (
        .ent_vld (e_vld[g]),
        .ent_sup (e_sup[g]),
        .ent_glb (e_perm[g][BIT_G]),
        .ent_vpn (e_vpn[g]),
        .ent_ctx (e_ctx[g]),
        .q_vpn   (lk_vpn),
        .q_ctx   (lk_ctx),
        .hit     (hit_vec[g])
      );
    end
  endgenerate

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_vec  (e_vld),
    .wr_fire  (fill_fire),
    .victim   (victim),
    .any_free (any_free)
  );

  // valid bits: flushes win over refill
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld <= '0;
    end else if (flush_all) begin
      e_vld <= '0;
    end else if (flush_ctx_valid) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!e_perm[i][BIT_G] && (e_ctx[i] == flush_ctx)) e_vld[i] <= 1'b0;
      end
    end else if (fill_valid) begin
      e_vld[victim] <= 1'b1;
    end
  end

  // payload, no reset needed
  always_ff @(posedge clk) begin
    if (fill_fire) begin
      e_sup[victim]  <= fill_super;
      e_vpn[victim]  <= fill_vpn;
      e_ctx[victim]  <= fill_ctx;
      e_ppn[victim]  <= fill_ppn;
      e_perm[victim] <= fill_perm;
    end
  end

  // registered result
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && hit_any;
      rsp_miss  <= lk_valid && !hit_any;
      if (lk_valid) begin
        rsp_ppn   <= hit_any ? eff_ppn(e_ppn[hit_idx], lk_vpn, e_sup[hit_idx]) : '0;
        rsp_perm  <= hit_any ? e_perm[hit_idx] : '0;
        rsp_paddr <= hit_any ? {eff_ppn(e_ppn[hit_idx], lk_vpn, e_sup[hit_idx]), lk_off}
                             : '0;
      end
    end
  end

  // R2
  lk_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

  // R3
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_hit -> (rsp_paddr[11:0] == $past(lk_off))));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (e_vld == '0));

  // R10
  flush_keeps_glb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_ctx_valid && !flush_all && e_vld[0] && e_perm[0][BIT_G]) |=> e_vld[0]);
endmodule

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [11:0] lk_off = '0;
  logic [8:0]  lk_ctx = '0;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [8:0]  fill_ctx = '0;
  logic [21:0] fill_ppn = '0;
  logic [6:0]  fill_perm = '0;
  logic        fill_super = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_ctx_valid = 1'b0;
  logic [8:0]  flush_ctx = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [21:0] rsp_ppn;
  logic [6:0]  rsp_perm;
  logic [33:0] rsp_paddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #10ns clk = ~clk;

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off), .lk_ctx(lk_ctx),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .fill_super(fill_super),
    .flush_all(flush_all), .flush_ctx_valid(flush_ctx_valid), .flush_ctx(flush_ctx),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm), .rsp_paddr(rsp_paddr)
  );

  // expected item: {hit, ppn[22], perm[7], paddr[34]}
  task automatic look(input logic [19:0] v, input logic [11:0] o, input logic [8:0] c,
                      input bit eh, input logic [21:0] ep, input logic [6:0] eperm,
                      input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_off = o; lk_ctx = c;
    exp_q.push_back({eh, ep, eperm, ep, o});
    tag_q.push_back(tag);
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] v, input logic [8:0] c, input logic [21:0] p,
                      input logic [6:0] perm, input bit sup);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = v; fill_ctx = c; fill_ppn = p;
    fill_perm = perm; fill_super = sup;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      logic [63:0] e;
      string t;
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected response hit=%0d expected none", rsp_hit);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[63]) begin
          if (!(rsp_hit && !rsp_miss && rsp_ppn == e[62:41] && rsp_perm == e[40:34]
                && rsp_paddr == e[33:0])) begin
            n_fail++;
            $display("FAIL %s: hit=%0d ppn=%h perm=%h paddr=%h expected hit=1 ppn=%h perm=%h paddr=%h",
                     t, rsp_hit, rsp_ppn, rsp_perm, rsp_paddr, e[62:41], e[40:34], e[33:0]);
          end
        end else if (!(rsp_miss && !rsp_hit)) begin
          n_fail++;
          $display("FAIL %s: hit=%0d miss=%0d expected hit=0 miss=1", t, rsp_hit, rsp_miss);
        end
      end
    end
  end

  localparam logic [21:0] S_PPN = 22'h2A_BC00;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    n_run++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: rsp_valid=%0d expected 0", rsp_valid);
    end
    look(20'h12345, 12'h000, 9'd1, 0, '0, '0, "R1");

    // R3, R4
    fill(20'h12345, 9'd1, 22'h1F_0001, 7'h23, 0);
    look(20'h12345, 12'hABC, 9'd1, 1, 22'h1F_0001, 7'h23, "R3");
    look(20'h12345, 12'h001, 9'd2, 0, '0, '0, "R4");
    look(20'h12346, 12'h001, 9'd1, 0, '0, '0, "R4");

    // R5 global
    fill(20'h0BEEF, 9'd1, 22'h00_0777, 7'h14, 0);
    look(20'h0BEEF, 12'h010, 9'd5, 1, 22'h00_0777, 7'h14, "R5");
    look(20'h0BEEF, 12'hFFF, 9'd1, 1, 22'h00_0777, 7'h14, "R5");

    // R6 superpage
    fill({10'h2AB, 10'h000}, 9'd1, S_PPN, 7'h27, 1);
    look({10'h2AB, 10'h155}, 12'h123, 9'd1, 1, {S_PPN[21:10], 10'h155}, 7'h27, "R6");
    look({10'h2AB, 10'h3FF}, 12'h000, 9'd1, 1, {S_PPN[21:10], 10'h3FF}, 7'h27, "R6");
    look({10'h2AC, 10'h155}, 12'h123, 9'd1, 0, '0, '0, "R6");

    // R11 same-cycle lookup and refill
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 20'h00ABC; lk_off = 12'h444; lk_ctx = 9'd2;
    fill_valid = 1'b1; fill_vpn = 20'h00ABC; fill_ctx = 9'd2;
    fill_ppn = 22'h33_3333; fill_perm = 7'h03; fill_super = 1'b0;
    exp_q.push_back({1'b0, 22'h0, 7'h0, 34'h0});
    tag_q.push_back("R11");
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0;
    look(20'h00ABC, 12'h444, 9'd2, 1, 22'h33_3333, 7'h03, "R11");

    // R10 context flush
    @(negedge clk);
    flush_ctx_valid = 1'b1; flush_ctx = 9'd1;
    @(negedge clk);
    flush_ctx_valid = 1'b0;
    look(20'h12345, 12'h000, 9'd1, 0, '0, '0, "R10");
    look({10'h2AB, 10'h155}, 12'h000, 9'd1, 0, '0, '0, "R10");
    look(20'h0BEEF, 12'h020, 9'd1, 1, 22'h00_0777, 7'h14, "R10");
    look(20'h00ABC, 12'h444, 9'd2, 1, 22'h33_3333, 7'h03, "R10");

    // R9 full flush with a simultaneous refill
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vpn = 20'h0DEAD; fill_ctx = 9'd2;
    fill_ppn = 22'h01_1111; fill_perm = 7'h01; fill_super = 1'b0;
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(20'h0BEEF, 12'h000, 9'd1, 0, '0, '0, "R9");
    look(20'h00ABC, 12'h000, 9'd2, 0, '0, '0, "R9");
    look(20'h0DEAD, 12'h000, 9'd2, 0, '0, '0, "R9");

    // R7/R8 replacement: V3 lives in context 4
    for (int i = 0; i < 8; i++)
      fill(20'h00100 + 20'(i), (i == 3) ? 9'd4 : 9'd3, 22'h00_0200 + 22'(i), 7'h01, 0);
    for (int i = 0; i < 8; i++)
      look(20'h00100 + 20'(i), 12'h000, (i == 3) ? 9'd4 : 9'd3, 1,
           22'h00_0200 + 22'(i), 7'h01, "R7");
    fill(20'h00108, 9'd3, 22'h00_0208, 7'h01, 0);  // evicts slot 0
    look(20'h00100, 12'h000, 9'd3, 0, '0, '0, "R8");
    look(20'h00108, 12'h000, 9'd3, 1, 22'h00_0208, 7'h01, "R8");
    look(20'h00101, 12'h000, 9'd3, 1, 22'h00_0201, 7'h01, "R8");
    fill(20'h00109, 9'd3, 22'h00_0209, 7'h01, 0);  // evicts slot 1
    look(20'h00101, 12'h000, 9'd3, 0, '0, '0, "R8");
    look(20'h00102, 12'h000, 9'd3, 1, 22'h00_0202, 7'h01, "R8");
    @(negedge clk);
    flush_ctx_valid = 1'b1; flush_ctx = 9'd4;     // frees slot 3
    @(negedge clk);
    flush_ctx_valid = 1'b0;
    fill(20'h0010A, 9'd3, 22'h00_020A, 7'h01, 0);  // goes into slot 3
    look(20'h00102, 12'h000, 9'd3, 1, 22'h00_0202, 7'h01, "R7");
    look(20'h0010A, 12'h000, 9'd3, 1, 22'h00_020A, 7'h01, "R7");
    fill(20'h0010B, 9'd3, 22'h00_020B, 7'h01, 0);  // pointer still at 2
    look(20'h00102, 12'h000, 9'd3, 0, '0, '0, "R8");
    look(20'h00104, 12'h000, 9'd3, 1, 22'h00_0204, 7'h01, "R8");
    look(20'h0010B, 12'h000, 9'd3, 1, 22'h00_020B, 7'h01, "R8");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d responses missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4ms;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule